// File: doc/BRIEF.md
# OFDM Training Least-Squares Channel Estimator

This block sits right after the 64-point FFT of an OFDM receiver. It is used while a multi-antenna training frame is being received. The frame carries one training symbol for each transmit/receive antenna pair, so a link with nT transmit and nR receive antennas sends nT·nR symbols. Each symbol is sent through identity beamformers, which means each symbol carries exactly one antenna pair.

The block takes one complex frequency-domain sample per cycle. Each sample comes with its FFT bin number and a marker that flags the first sample of a symbol. The block discards the DC bin and the guard bins. For each of the 52 occupied subcarriers it removes the known BPSK training value. Because that value is ±1, the least-squares division becomes a conditional negation with saturation, and no multiplier is needed.

Each estimate leaves the block one cycle after its sample arrives. It is tagged with its transmit index, receive index and subcarrier index. A one-cycle completion pulse comes with the final estimate of the frame. A start strobe loads the antenna counts and arms the block for a new frame.

Top module: `ofdm_ls_chest`

## Requirements
- R1: While reset is held and on the first cycle after it, `est_valid` and `est_done` are low.
- R2: Active subcarrier numbering:
  - FFT bins 38..63 map to subcarrier index 0..25 (bin minus 38).
  - FFT bins 1..26 map to subcarrier index 26..51 (bin plus 25).
  - Bin 0 and bins 27..37 never produce an estimate.
- R3: Estimate value:
  - The training value is -1 at subcarrier indices 2, 3, 6, 8, 15, 16, 19, 21, 27, 28, 31, 33, 35, 36, 37, 38, 39, 42, 43, 45 and 47. It is +1 at every other index 0..51.
  - Where the training value is -1, both the real and the imaginary part of the estimate are the negated input.
  - Where it is +1, both parts are passed through unchanged.
- R4: Negating the most negative input value (-2^(SW-1)) gives the most positive value (2^(SW-1)-1).
- R5: An estimate appears on the outputs exactly one clock cycle after the accepted sample, with `est_valid` high for that one cycle per sample.
- R6: `cfg_start` loads the antenna counts and arms the block. A count of 0 is taken as 1, and a count above the parameter maximum is taken as that maximum. `cfg_start` aborts any frame in progress, and a sample presented in the same cycle is ignored.
- R7: Training symbol k of a frame (counted from 0) carries transmit index k mod nT and receive index k div nT.
- R8: Samples are ignored in two cases: when no frame is armed, and after arming but before the first sample that carries the symbol-start marker.
- R9: Symbol-start handling:
  - A sample with the symbol-start marker moves the block to the next antenna pair.
  - During the final pair, a marker does not advance the pair; it restarts that symbol's count of stored subcarriers.
- R10: Frame completion:
  - `est_done` is high together with the estimate that is the 52nd stored subcarrier of the final symbol.
  - That estimate closes the frame, and later samples are ignored until the next `cfg_start`.
- R11: A cycle with `smp_valid` low has no effect, even when `smp_sos` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Arms a new training frame and loads the antenna counts |
| cfg_ntx | input | $clog2(NTX_MAX+1) | Number of transmit antennas |
| cfg_nrx | input | $clog2(NRX_MAX+1) | Number of receive antennas |
| smp_valid | input | 1 | Sample qualifier |
| smp_sos | input | 1 | First sample of a training symbol |
| smp_bin | input | 6 | FFT bin number of the sample |
| smp_re | input | SW | Real part of the sample, two's complement |
| smp_im | input | SW | Imaginary part of the sample, two's complement |
| est_valid | output | 1 | Estimate qualifier |
| est_tx | output | TXI_W | Transmit antenna index of the estimate |
| est_rx | output | RXI_W | Receive antenna index of the estimate |
| est_sc | output | 6 | Active subcarrier index 0..51 |
| est_re | output | SW | Real part of the estimate |
| est_im | output | SW | Imaginary part of the estimate |
| est_done | output | 1 | Final estimate of the frame |

## Verification
- A wrong pair counter shows up on `est_tx` and `est_rx` at the very first sample of the symbol where it goes wrong, and the error then persists for the rest of the frame.
- A wrong per-symbol subcarrier count does not show immediately. It appears only in the final symbol, as an `est_done` pulse that is missing or misplaced, and possibly as a later estimate that should have been dropped.
- A wrong bin map or training pattern entry shows on one subcarrier index, in one symbol. The bench therefore sends every bin in natural and shuffled orders, and compares each output cycle against a model built from the requirements.

// File: rtl/ofdm_ls_chest_pkg.sv
`timescale 1ns/1ps
package ofdm_ls_chest_pkg;

    localparam int FFT_N  = 64;
    localparam int BIN_W  = $clog2(FFT_N);
    localparam int N_ACT  = 52;
    localparam int SC_W   = BIN_W;
    localparam int HALF   = N_ACT / 2;
    localparam int NEG_LO = FFT_N - HALF;   // first bin of the negative half

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic            active;
        logic [SC_W-1:0] sc;
        logic            neg;
    } bin_info_t;

    // Training value sign per active subcarrier index: 1 means -1.
    function automatic logic pilot_neg(input logic [SC_W-1:0] sc);
        case (sc)
            6'd2, 6'd3, 6'd6, 6'd8, 6'd15, 6'd16, 6'd19, 6'd21,
            6'd27, 6'd28, 6'd31, 6'd33, 6'd35, 6'd36, 6'd37,
            6'd38, 6'd39, 6'd42, 6'd43, 6'd45, 6'd47: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bin_info_t map_bin(input logic [BIN_W-1:0] b);
        bin_info_t r;
        r.active = 1'b0;
        r.sc     = '0;
        r.neg    = 1'b0;
        if (b >= BIN_W'(1) && b <= BIN_W'(HALF)) begin
            r.active = 1'b1;
            r.sc     = b + SC_W'(HALF - 1);
        end else if (b >= BIN_W'(NEG_LO)) begin
            r.active = 1'b1;
            r.sc     = b - SC_W'(NEG_LO);
        end
        if (r.active) r.neg = pilot_neg(r.sc);
        return r;
    endfunction

endpackage

// File: rtl/chest_binmap.sv
`timescale 1ns/1ps
module chest_binmap
    import ofdm_ls_chest_pkg::*;
(
    input  logic [BIN_W-1:0] bin_i,
    output bin_info_t        info_o
);

    assign info_o = map_bin(bin_i);

    always_comb begin
        if (info_o.active)
            a_r2_sc_bound: assert (info_o.sc < SC_W'(N_ACT));
    end

endmodule

// File: rtl/chest_seq.sv
`timescale 1ns/1ps
module chest_seq
    import ofdm_ls_chest_pkg::*;
#(
    parameter  int NTX_MAX = 4,
    parameter  int NRX_MAX = 4,
    localparam int TXC_W   = $clog2(NTX_MAX + 1),
    localparam int RXC_W   = $clog2(NRX_MAX + 1),
    localparam int TXI_W   = (NTX_MAX > 1) ? $clog2(NTX_MAX) : 1,
    localparam int RXI_W   = (NRX_MAX > 1) ? $clog2(NRX_MAX) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_start,
    input  logic [TXC_W-1:0] cfg_ntx,
    input  logic [RXC_W-1:0] cfg_nrx,
    input  logic             smp_valid,
    input  logic             smp_sos,
    input  logic             bin_active,
    output logic             store_o,
    output logic [TXI_W-1:0] tx_o,
    output logic [RXI_W-1:0] rx_o,
    output logic             finish_o
);

    localparam logic [SC_W-1:0] CNT_LAST = SC_W'(N_ACT - 1);
    localparam logic [SC_W-1:0] CNT_SAT  = '1;

    seq_state_t       state_q;
    logic [TXC_W-1:0] ntx_q;
    logic [RXC_W-1:0] nrx_q;
    logic [TXI_W-1:0] tx_q, cur_tx;
    logic [RXI_W-1:0] rx_q, cur_rx;
    logic [SC_W-1:0]  cnt_q, cur_cnt, cnt_nx;
    logic [TXC_W-1:0] ntx_cl;
    logic [RXC_W-1:0] nrx_cl;
    logic             take, at_last, cur_last, store, finish;

    // Clamp the requested antenna counts into 1..MAX
    always_comb begin
        if (cfg_ntx == '0)                      ntx_cl = TXC_W'(1);
        else if (cfg_ntx > TXC_W'(NTX_MAX))     ntx_cl = TXC_W'(NTX_MAX);
        else                                    ntx_cl = cfg_ntx;
        if (cfg_nrx == '0)                      nrx_cl = RXC_W'(1);
        else if (cfg_nrx > RXC_W'(NRX_MAX))     nrx_cl = RXC_W'(NRX_MAX);
        else                                    nrx_cl = cfg_nrx;
    end

    // Pair and count that apply to the sample on the inputs this cycle
    always_comb begin
        take    = smp_valid && !cfg_start &&
                  ((state_q == ST_ARMED && smp_sos) || state_q == ST_RUN);
        at_last = (TXC_W'(tx_q) == ntx_q - TXC_W'(1)) &&
                  (RXC_W'(rx_q) == nrx_q - RXC_W'(1));
        cur_tx  = tx_q;
        cur_rx  = rx_q;
        cur_cnt = cnt_q;
        if (take && smp_sos) begin
            cur_cnt = '0;
            if (state_q == ST_ARMED) begin
                cur_tx = '0;
                cur_rx = '0;
            end else if (!at_last) begin
                if (TXC_W'(tx_q) == ntx_q - TXC_W'(1)) begin
                    cur_tx = '0;
                    cur_rx = rx_q + RXI_W'(1);
                end else begin
                    cur_tx = tx_q + TXI_W'(1);
                end
            end
        end
        cur_last = (TXC_W'(cur_tx) == ntx_q - TXC_W'(1)) &&
                   (RXC_W'(cur_rx) == nrx_q - RXC_W'(1));
        store    = take && bin_active;
        finish   = store && cur_last && (cur_cnt == CNT_LAST);
        if (store && cur_cnt != CNT_SAT) cnt_nx = cur_cnt + SC_W'(1);
        else                             cnt_nx = cur_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ntx_q   <= TXC_W'(1);
            nrx_q   <= RXC_W'(1);
            tx_q    <= '0;
            rx_q    <= '0;
            cnt_q   <= '0;
        end else if (cfg_start) begin
            state_q <= ST_ARMED;
            ntx_q   <= ntx_cl;
            nrx_q   <= nrx_cl;
            tx_q    <= '0;
            rx_q    <= '0;
            cnt_q   <= '0;
        end else if (take) begin
            state_q <= finish ? ST_IDLE : ST_RUN;
            tx_q    <= cur_tx;
            rx_q    <= cur_rx;
            cnt_q   <= cnt_nx;
        end
    end

    assign store_o  = store;
    assign tx_o     = cur_tx;
    assign rx_o     = cur_rx;
    assign finish_o = finish;

    // R6: loaded counts always lie inside 1..MAX
    a_r6_counts_in_range: assert property (@(posedge clk) disable iff (rst)
        (ntx_q != '0) && (ntx_q <= TXC_W'(NTX_MAX)) &&
        (nrx_q != '0) && (nrx_q <= RXC_W'(NRX_MAX)));

    // R7: the pair held while running stays below the loaded counts
    a_r7_pair_in_range: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |->
            (TXC_W'(tx_q) < ntx_q) && (RXC_W'(rx_q) < nrx_q));

    // R10: a completed frame leaves the sequencer idle
    a_r10_idle_after_finish: assert property (@(posedge clk) disable iff (rst)
        (finish && !cfg_start) |=> (state_q == ST_IDLE));

    // R8: nothing is stored unless a frame is armed or running
    a_r8_no_store_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !store);

    // R11: a cycle with no valid sample leaves the pair unchanged
    a_r11_hold_without_valid: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !cfg_start) |=> $stable(tx_q) && $stable(rx_q) && $stable(cnt_q));

endmodule

// File: rtl/chest_flip.sv
`timescale 1ns/1ps
module chest_flip #(
    parameter int SW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          neg,
    input  logic [SW-1:0] re_i,
    input  logic [SW-1:0] im_i,
    output logic          valid_o,
    output logic [SW-1:0] re_o,
    output logic [SW-1:0] im_o
);

    localparam int           LANES = 2;
    localparam logic [SW-1:0] VMIN = {1'b1, {(SW-1){1'b0}}};
    localparam logic [SW-1:0] VMAX = {1'b0, {(SW-1){1'b1}}};

    logic [SW-1:0] lane_in [LANES];
    logic [SW-1:0] lane_q  [LANES];

    assign lane_in[0] = re_i;
    assign lane_in[1] = im_i;

    always_ff @(posedge clk) begin
        if (rst) valid_o <= 1'b0;
        else     valid_o <= in_valid;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SW-1:0] flipped;

        always_comb begin
            if (lane_in[g] == VMIN) flipped = VMAX;
            else                    flipped = -lane_in[g];
        end

        always_ff @(posedge clk) begin
            if (rst)           lane_q[g] <= '0;
            else if (in_valid) lane_q[g] <= neg ? flipped : lane_in[g];
        end

        // R4: the most negative value flips to the most positive value
        a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
            (in_valid && neg && lane_in[g] == VMIN) |=> (lane_q[g] == VMAX));

        // R3: outside saturation, the magnitude is kept
        a_r3_magnitude_kept: assert property (@(posedge clk) disable iff (rst)
            (in_valid && lane_in[g] != VMIN) |=>
                (lane_q[g] == $past(lane_in[g])) || (lane_q[g] == -$past(lane_in[g])));
    end

    assign re_o = lane_q[0];
    assign im_o = lane_q[1];

endmodule

// File: rtl/ofdm_ls_chest.sv
`timescale 1ns/1ps
module ofdm_ls_chest
    import ofdm_ls_chest_pkg::*;
#(
    parameter  int NTX_MAX = 4,
    parameter  int NRX_MAX = 4,
    parameter  int SW      = 12,
    localparam int TXC_W   = $clog2(NTX_MAX + 1),
    localparam int RXC_W   = $clog2(NRX_MAX + 1),
    localparam int TXI_W   = (NTX_MAX > 1) ? $clog2(NTX_MAX) : 1,
    localparam int RXI_W   = (NRX_MAX > 1) ? $clog2(NRX_MAX) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_start,
    input  logic [TXC_W-1:0] cfg_ntx,
    input  logic [RXC_W-1:0] cfg_nrx,
    input  logic             smp_valid,
    input  logic             smp_sos,
    input  logic [BIN_W-1:0] smp_bin,
    input  logic [SW-1:0]    smp_re,
    input  logic [SW-1:0]    smp_im,
    output logic             est_valid,
    output logic [TXI_W-1:0] est_tx,
    output logic [RXI_W-1:0] est_rx,
    output logic [SC_W-1:0]  est_sc,
    output logic [SW-1:0]    est_re,
    output logic [SW-1:0]    est_im,
    output logic             est_done
);

    bin_info_t        info;
    logic             store, finish;
    logic [TXI_W-1:0] cur_tx;
    logic [RXI_W-1:0] cur_rx;

    chest_binmap u_map (
        .bin_i  (smp_bin),
        .info_o (info)
    );

    chest_seq #(
        .NTX_MAX (NTX_MAX),
        .NRX_MAX (NRX_MAX)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg_start  (cfg_start),
        .cfg_ntx    (cfg_ntx),
        .cfg_nrx    (cfg_nrx),
        .smp_valid  (smp_valid),
        .smp_sos    (smp_sos),
        .bin_active (info.active),
        .store_o    (store),
        .tx_o       (cur_tx),
        .rx_o       (cur_rx),
        .finish_o   (finish)
    );

    chest_flip #(
        .SW (SW)
    ) u_flip (
        .clk      (clk),
        .rst      (rst),
        .in_valid (store),
        .neg      (info.neg),
        .re_i     (smp_re),
        .im_i     (smp_im),
        .valid_o  (est_valid),
        .re_o     (est_re),
        .im_o     (est_im)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            est_tx   <= '0;
            est_rx   <= '0;
            est_sc   <= '0;
            est_done <= 1'b0;
        end else begin
            est_done <= finish;
            if (store) begin
                est_tx <= cur_tx;
                est_rx <= cur_rx;
                est_sc <= info.sc;
            end
        end
    end

    // R10: completion only comes together with an estimate
    a_r10_done_with_estimate: assert property (@(posedge clk) disable iff (rst)
        est_done |-> est_valid);

    // R10: after completion the next cycle carries no estimate
    a_r10_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        est_done |=> !est_valid);

    // R5: an estimate follows a valid sample not masked by cfg_start
    a_r5_estimate_has_source: assert property (@(posedge clk) disable iff (rst)
        est_valid |-> ($past(smp_valid) && !$past(cfg_start)));

    // R2: estimates carry an index inside the active range
    a_r2_index_range: assert property (@(posedge clk) disable iff (rst)
        est_valid |-> (est_sc < SC_W'(N_ACT)));

    // R1: after reset the outputs start quiet
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!est_valid && !est_done));

endmodule

// File: tb/ofdm_ls_chest_tb_top.sv
`timescale 1ns/1ps
module ofdm_ls_chest_tb_top;

    localparam int SW = 12;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_start;
    logic [2:0]  cfg_ntx, cfg_nrx;
    logic        smp_valid, smp_sos;
    logic [5:0]  smp_bin;
    logic [11:0] smp_re, smp_im;
    logic        est_valid, est_done;
    logic [1:0]  est_tx, est_rx;
    logic [5:0]  est_sc;
    logic [11:0] est_re, est_im;

    int nchk = 0;
    int nerr = 0;

    // reference state built from the requirements
    int m_state = 0;   // 0 idle, 1 armed, 2 running
    int m_ntx = 1, m_nrx = 1, m_tx = 0, m_rx = 0, m_cnt = 0;

    always #10 clk = ~clk;

    ofdm_ls_chest dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_start (cfg_start),
        .cfg_ntx   (cfg_ntx),
        .cfg_nrx   (cfg_nrx),
        .smp_valid (smp_valid),
        .smp_sos   (smp_sos),
        .smp_bin   (smp_bin),
        .smp_re    (smp_re),
        .smp_im    (smp_im),
        .est_valid (est_valid),
        .est_tx    (est_tx),
        .est_rx    (est_rx),
        .est_sc    (est_sc),
        .est_re    (est_re),
        .est_im    (est_im),
        .est_done  (est_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R2 bin map
    function automatic int ref_sc(input int b);
        if (b >= 1 && b <= 26) return b + 25;
        if (b >= 38 && b <= 63) return b - 38;
        return -1;
    endfunction

    // R3 training sign
    function automatic bit ref_neg(input int sc);
        int negs[21] = '{2, 3, 6, 8, 15, 16, 19, 21, 27, 28, 31, 33, 35,
                         36, 37, 38, 39, 42, 43, 45, 47};
        foreach (negs[i]) if (negs[i] == sc) return 1'b1;
        return 1'b0;
    endfunction

    // R3/R4 value
    function automatic logic [11:0] ref_val(input logic [11:0] x, input bit n);
        if (!n) return x;
        if (x == 12'h800) return 12'h7FF;
        return -x;
    endfunction

    function automatic int clamp(input int v, input int mx);
        if (v == 0) return 1;
        if (v > mx) return mx;
        return v;
    endfunction

    task automatic step(input bit v, input bit sos, input int bin,
                        input logic [11:0] re, input logic [11:0] im,
                        input bit cfg, input int cnt_t, input int cnt_r,
                        input string tag);
        bit          e_valid = 1'b0;
        bit          e_done  = 1'b0;
        int          e_sc = 0, e_tx = 0, e_rx = 0;
        logic [11:0] e_re = '0, e_im = '0;
        @(negedge clk);
        cfg_start = cfg;
        cfg_ntx   = 3'(cnt_t);
        cfg_nrx   = 3'(cnt_r);
        smp_valid = v;
        smp_sos   = sos;
        smp_bin   = 6'(bin);
        smp_re    = re;
        smp_im    = im;
        if (cfg) begin
            m_state = 1;
            m_ntx = clamp(cnt_t, 4);
            m_nrx = clamp(cnt_r, 4);
            m_tx = 0; m_rx = 0; m_cnt = 0;
        end else if (v && ((m_state == 1 && sos) || m_state == 2)) begin
            if (sos) begin
                m_cnt = 0;
                if (m_state == 1) begin
                    m_tx = 0; m_rx = 0;
                end else if (!(m_tx == m_ntx - 1 && m_rx == m_nrx - 1)) begin
                    if (m_tx == m_ntx - 1) begin m_tx = 0; m_rx++; end
                    else m_tx++;
                end
            end
            m_state = 2;
            if (ref_sc(bin) >= 0) begin
                e_valid = 1'b1;
                e_sc = ref_sc(bin);
                e_tx = m_tx; e_rx = m_rx;
                e_re = ref_val(re, ref_neg(e_sc));
                e_im = ref_val(im, ref_neg(e_sc));
                m_cnt++;
                if (m_tx == m_ntx - 1 && m_rx == m_nrx - 1 && m_cnt == 52) begin
                    e_done = 1'b1;
                    m_state = 0;
                end
            end
        end
        @(posedge clk);
        #1;
        chk(est_valid == e_valid, tag, "est_valid", int'(est_valid), int'(e_valid));
        chk(est_done == e_done, "R10", "est_done", int'(est_done), int'(e_done));
        if (e_valid && est_valid) begin
            chk(int'(est_sc) == e_sc, "R2", "est_sc", int'(est_sc), e_sc);
            chk(int'(est_tx) == e_tx, "R7", "est_tx", int'(est_tx), e_tx);
            chk(int'(est_rx) == e_rx, "R7", "est_rx", int'(est_rx), e_rx);
            chk(est_re == e_re, "R3", "est_re", int'(est_re), int'(e_re));
            chk(est_im == e_im, "R3", "est_im", int'(est_im), int'(e_im));
        end
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 0, '0, '0, 1'b0, 0, 0, tag);
    endtask

    task automatic cfg(input int t, input int r);
        step(1'b0, 1'b0, 0, '0, '0, 1'b1, t, r, "R6");
    endtask

    // one training symbol of up to 64 bins; shuffled order, MIN mixing, gaps
    task automatic send_sym(input bit shuf, input bit minmix, input int nbins);
        int order[64];
        for (int i = 0; i < 64; i++) order[i] = i;
        if (shuf) begin
            for (int i = 63; i > 0; i--) begin
                int j = int'($urandom % (i + 1));
                int t = order[i];
                order[i] = order[j];
                order[j] = t;
            end
        end
        for (int i = 0; i < nbins; i++) begin
            logic [11:0] re = 12'($urandom);
            logic [11:0] im = 12'($urandom);
            if (minmix && ($urandom % 4 == 0)) re = 12'h800;
            if (minmix && ($urandom % 4 == 0)) im = 12'h800;
            if (i > 0 && ($urandom % 8 == 0))
                step(1'b0, 1'($urandom), order[i], 12'($urandom), 12'($urandom),
                     1'b0, 0, 0, "R11");
            step(1'b1, i == 0, order[i], re, im, 1'b0, 0, 0, "R5");
        end
    endtask

    initial begin
        #(20 * 150000);
        nerr++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        cfg_start = 0; cfg_ntx = 0; cfg_nrx = 0;
        smp_valid = 0; smp_sos = 0; smp_bin = 0; smp_re = 0; smp_im = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(est_valid == 1'b0, "R1", "est_valid in reset", int'(est_valid), 0);
        chk(est_done == 1'b0, "R1", "est_done in reset", int'(est_done), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk(est_valid == 1'b0, "R1", "est_valid after reset", int'(est_valid), 0);
        chk(est_done == 1'b0, "R1", "est_done after reset", int'(est_done), 0);

        // R8: no frame armed
        step(1'b1, 1'b1, 5, 12'h123, 12'h045, 1'b0, 0, 0, "R8");
        step(1'b1, 1'b0, 40, 12'h321, 12'h054, 1'b0, 0, 0, "R8");

        // 2x2 frame in natural order, samples before the first marker dropped
        cfg(2, 2);
        step(1'b1, 1'b0, 3, 12'h111, 12'h222, 1'b0, 0, 0, "R8");
        step(1'b0, 1'b1, 3, 12'h111, 12'h222, 1'b0, 0, 0, "R11");
        for (int s = 0; s < 4; s++) send_sym(1'b0, 1'b0, 64);
        // R10: frame closed, markers ignored
        step(1'b1, 1'b1, 1, 12'h0AA, 12'h0BB, 1'b0, 0, 0, "R10");
        step(1'b1, 1'b0, 2, 12'h0AA, 12'h0BB, 1'b0, 0, 0, "R10");

        // R6 clamp 0 -> 1: 1x3 frame, shuffled bins
        cfg(0, 3);
        for (int s = 0; s < 3; s++) send_sym(1'b1, 1'b0, 64);
        idle("R10");

        // R6 clamp 7 -> 4 and R4 saturation: 4x4 frame
        cfg(7, 4);
        for (int s = 0; s < 16; s++) send_sym(s[0], 1'b1, 64);

        // R4 directed: most negative value at a -1 subcarrier (bin 40 -> index 2)
        cfg(1, 1);
        step(1'b1, 1'b1, 40, 12'h800, 12'h800, 1'b0, 0, 0, "R4");
        step(1'b1, 1'b0, 38, 12'h800, 12'h801, 1'b0, 0, 0, "R4");

        // R6 abort: cfg_start mid-frame with a valid sample in the same cycle
        cfg(2, 1);
        send_sym(1'b0, 1'b0, 30);
        step(1'b1, 1'b1, 45, 12'h155, 12'h2AA, 1'b1, 1, 1, "R6");
        send_sym(1'b1, 1'b0, 64);
        idle("R10");

        // R9: extra marker during the final pair restarts the count
        cfg(1, 2);
        send_sym(1'b0, 1'b0, 64);
        send_sym(1'b1, 1'b0, 40);
        send_sym(1'b1, 1'b0, 64);
        idle("R9");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule